// File: doc/BRIEF.md
# Indexed Control Port with Dual Byte Queues

This block connects a host bus to a local controller through two byte queues, one per direction, plus a small set of control registers that the host reaches indirectly. The host sees only two addresses. The data address pushes bytes toward the local side and pops bytes that the local side sent. The control address works as a pointer in its idle state. Writing a select code there aims the very next control access at one internal register. After that one access, the control address goes back to pointer mode. A read at the control address in pointer mode returns a bit-mapped status byte.

The registers behind the pointer are:
- a command register, which can reset the queue logic or switch the status view to the local side's perspective;
- an interrupt mask;
- a byte-match value;
- an occupancy threshold;
- an outbound mailbox;
- an inbound mailbox.

The status byte carries a sticky reset flag. That flag clears when the status is read, and it interrupts the host even when every mask bit is clear. Host interrupts stay gated off after any reset until the local controller opens them. The host polls the outbound mailbox to learn whether the local side has taken a message: it reads back as zero once the message is consumed.

Top module: `fifo_regport`

## Requirements
- R1: A write at the control address (host_addr=1) in pointer mode latches select code host_wdata[2:0] (1 command, 2 mask, 3 byte-match, 4 outbound mailbox, 5 threshold, 6 inbound mailbox; 0 and 7 reach nothing and read as 0x00). Only the next control-address read or write reaches that register, and pointer mode returns after it. Data-address accesses in between do not consume the selection.
- R2: A control-address read in pointer mode returns status {bit7 reset flag, bit6 outbound queue full, bit5 inbound queue empty, bit4 outbound almost full, bit3 inbound almost empty, bit2 inbound mailbox full, bit1 byte-match present, bit0 zero} and clears bit7.
- R3: Asserting rst_n low, or writing the command register with bit7 set, sets the reset flag, empties both queues, clears both mailboxes and their full flags, clears the status-view switch, and gates host interrupts off. A command reset leaves the mask, byte-match and threshold registers unchanged.
- R4: A command write with bit7 clear copies bit6 into the view switch. The command register reads back as {0, switch, 000000}. While the switch is set, the status reads {reset flag, inbound queue full, outbound queue empty, 0, 0, outbound mailbox full, 0, 0}.
- R5: Each queue holds DEPTH (512) bytes in order. A push to a full queue is dropped. A pop from an empty queue returns 0x00 and has no effect.
- R6: With threshold N, status bit3 is set while the inbound count is at most N, and status bit4 is set while the outbound count is at least DEPTH-N.
- R7: Each inbound byte is tagged when it enters if it equals the byte-match register. Status bit1 is set while any tagged byte remains queued, including when a tagged byte leaves in the same cycle that another tagged byte enters.
- R8: A host write to the outbound mailbox stores the byte and raises loc_mbox_full. A loc_mbox_rd pulse clears both, so the mailbox then reads back as 0x00.
- R9: loc_mbox_wr stores a byte in the inbound mailbox and sets status bit2. A host read of the inbound mailbox returns the byte and clears bit2.
- R10: The mask register stores bits 6..1 only and reads back with bits 7 and 0 zero. host_irq is high when the gate is open and either the reset flag is set or a status bit 6..1 is set together with its mask bit. A loc_irq_en pulse opens the gate, and either reset closes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_addr | input | 1 | 0 data address, 1 control address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid during the read cycle |
| host_irq | output | 1 | Host interrupt request |
| loc_wr | input | 1 | Local push into the inbound queue |
| loc_wdata | input | 8 | Byte pushed by the local side |
| loc_rd | input | 1 | Local pop from the outbound queue |
| loc_rdata | output | 8 | Head byte of the outbound queue (0 when empty) |
| loc_out_empty | output | 1 | Outbound queue empty |
| loc_in_full | output | 1 | Inbound queue full |
| loc_mbox_wr | input | 1 | Local write to the inbound mailbox |
| loc_mbox_wdata | input | 8 | Inbound mailbox byte |
| loc_mbox_rd | input | 1 | Local consumption of the outbound mailbox |
| loc_mbox_rdata | output | 8 | Outbound mailbox contents |
| loc_mbox_full | output | 1 | Outbound mailbox holds an unread byte |
| loc_irq_en | input | 1 | Pulse that opens the host interrupt gate |

## Verification
Two functions can fall in the same cycle here: the host popping a tagged byte out of the inbound queue, and the local side pushing another matching byte into it. The byte-match flag must stay set across that cycle. The bench provokes this by driving host_rd at the data address and loc_wr with the match value in one cycle. It then checks the popped byte and the status bit, and drains the queue to show that the flag falls only when the last tagged byte leaves. The occupancy thresholds are swept across every fill level of both queues, and each status read is compared against counts kept in the bench.

// File: rtl/regport_pkg.sv
package regport_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_CMD   = 3'd1,
    SEL_MASK  = 3'd2,
    SEL_MATCH = 3'd3,
    SEL_OMBX  = 3'd4,
    SEL_THR   = 3'd5,
    SEL_IMBX  = 3'd6,
    SEL_SPARE = 3'd7
  } sel_e;

  localparam int CMD_RST_BIT   = 7;
  localparam int CMD_SHIFT_BIT = 6;
endpackage

// File: rtl/regport_fifo.sv
module regport_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full & ~clr;
  assign do_pop  = pop & ~empty & ~clr;
  assign count   = cnt_q;
  assign dout    = empty ? '0 : mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  // R5: a push into a full queue must be dropped
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> full);
  // R5: a pop from an empty queue must leave it empty
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !clr) |=> empty);
endmodule

// File: rtl/regport_ptr.sv
module regport_ptr
  import regport_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_rd,
  input  sel_e sel_in,
  output logic armed,
  output sel_e sel
);
  logic armed_d;
  sel_e sel_d;

  always_comb begin
    armed_d = armed;
    sel_d   = sel;
    if (!armed && ctl_wr) begin
      armed_d = 1'b1;
      sel_d   = sel_in;
    end else if (armed && (ctl_wr || ctl_rd)) begin
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      sel   <= SEL_NONE;
    end else begin
      armed <= armed_d;
      sel   <= sel_d;
    end
  end

  // R1: one register access consumes the selection
  assert_oneshot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (ctl_wr || ctl_rd)) |=> !armed);
  // R1: a pointer write arms exactly one access
  assert_arm_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && ctl_wr) |=> (armed && sel == $past(sel_in)));
endmodule

// File: rtl/fifo_regport.sv
module fifo_regport
  import regport_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              host_irq,
  input  logic              loc_wr,
  input  logic [BYTE_W-1:0] loc_wdata,
  input  logic              loc_rd,
  output logic [BYTE_W-1:0] loc_rdata,
  output logic              loc_out_empty,
  output logic              loc_in_full,
  input  logic              loc_mbox_wr,
  input  logic [BYTE_W-1:0] loc_mbox_wdata,
  input  logic              loc_mbox_rd,
  output logic [BYTE_W-1:0] loc_mbox_rdata,
  output logic              loc_mbox_full,
  input  logic              loc_irq_en
);
  logic ctl_wr, ctl_rd, dat_wr, dat_rd;
  logic armed, reg_wr, reg_rd, st_rd, cmd_rst;
  sel_e sel;

  assign ctl_wr = host_wr & host_addr;
  assign ctl_rd = host_rd & host_addr & ~host_wr;
  assign dat_wr = host_wr & ~host_addr;
  assign dat_rd = host_rd & ~host_addr & ~host_wr;

  regport_ptr u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl_wr (ctl_wr),
    .ctl_rd (ctl_rd),
    .sel_in (sel_e'(host_wdata[2:0])),
    .armed  (armed),
    .sel    (sel)
  );

  assign reg_wr  = ctl_wr & armed;
  assign reg_rd  = ctl_rd & armed;
  assign st_rd   = ctl_rd & ~armed;
  assign cmd_rst = reg_wr && (sel == SEL_CMD) && host_wdata[CMD_RST_BIT];

  // control state
  logic              shift_q, shift_d, ombf_q, ombf_d, imbf_q, imbf_d;
  logic              rstf_q, rstf_d, gate_q, gate_d;
  logic [5:0]        mask_q, mask_d;
  logic [BYTE_W-1:0] match_q, match_d, thr_q, thr_d;
  logic [BYTE_W-1:0] omb_q, omb_d, imb_q, imb_d;
  logic [CW-1:0]     tcnt_q, tcnt_d;

  // queues
  logic [BYTE_W-1:0] out_dout;
  logic [BYTE_W:0]   in_dout;
  logic [CW-1:0]     out_cnt, in_cnt;
  logic              out_full, out_empty, in_full, in_empty;
  logic              tag_in, tag_push, tag_pop;

  regport_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_outq (
    .clk (clk), .rst_n (rst_n), .clr (cmd_rst),
    .push (dat_wr), .din (host_wdata), .pop (loc_rd), .dout (out_dout),
    .count (out_cnt), .full (out_full), .empty (out_empty)
  );

  assign tag_in = (loc_wdata == match_q);

  regport_fifo #(.W(BYTE_W + 1), .DEPTH(DEPTH)) u_inq (
    .clk (clk), .rst_n (rst_n), .clr (cmd_rst),
    .push (loc_wr), .din ({tag_in, loc_wdata}), .pop (dat_rd), .dout (in_dout),
    .count (in_cnt), .full (in_full), .empty (in_empty)
  );

  assign tag_push = loc_wr & ~in_full & tag_in;
  assign tag_pop  = dat_rd & ~in_empty & in_dout[BYTE_W];

  // status views
  logic              in_ae, out_af;
  logic [BYTE_W-1:0] st_norm, st_other;

  assign in_ae  = (in_cnt <= CW'(thr_q));
  assign out_af = (({1'b0, out_cnt} + (CW + 1)'(thr_q)) >= (CW + 1)'(DEPTH));

  assign st_norm  = {rstf_q, out_full, in_empty, out_af, in_ae, imbf_q, (tcnt_q != '0), 1'b0};
  assign st_other = {rstf_q, in_full, out_empty, 1'b0, 1'b0, ombf_q, 1'b0, 1'b0};

  always_comb begin
    shift_d = shift_q;
    mask_d  = mask_q;
    match_d = match_q;
    thr_d   = thr_q;
    omb_d   = omb_q;
    ombf_d  = ombf_q;
    imb_d   = imb_q;
    imbf_d  = imbf_q;
    rstf_d  = rstf_q;
    gate_d  = gate_q;
    tcnt_d  = tcnt_q + CW'(tag_push) - CW'(tag_pop);
    if (loc_mbox_rd) begin
      omb_d  = '0;
      ombf_d = 1'b0;
    end
    if (reg_rd && sel == SEL_IMBX) imbf_d = 1'b0;
    if (reg_wr) begin
      case (sel)
        SEL_CMD:   shift_d = host_wdata[CMD_SHIFT_BIT];
        SEL_MASK:  mask_d  = host_wdata[6:1];
        SEL_MATCH: match_d = host_wdata;
        SEL_THR:   thr_d   = host_wdata;
        SEL_OMBX: begin
          omb_d  = host_wdata;
          ombf_d = 1'b1;
        end
        default: ;
      endcase
    end
    if (loc_mbox_wr) begin
      imb_d  = loc_mbox_wdata;
      imbf_d = 1'b1;
    end
    if (st_rd)      rstf_d = 1'b0;
    if (loc_irq_en) gate_d = 1'b1;
    if (cmd_rst) begin
      shift_d = 1'b0;
      omb_d   = '0;
      ombf_d  = 1'b0;
      imb_d   = '0;
      imbf_d  = 1'b0;
      rstf_d  = 1'b1;
      gate_d  = 1'b0;
      tcnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= 1'b0;
      mask_q  <= '0;
      match_q <= '0;
      thr_q   <= '0;
      omb_q   <= '0;
      ombf_q  <= 1'b0;
      imb_q   <= '0;
      imbf_q  <= 1'b0;
      rstf_q  <= 1'b1;
      gate_q  <= 1'b0;
      tcnt_q  <= '0;
    end else begin
      shift_q <= shift_d;
      mask_q  <= mask_d;
      match_q <= match_d;
      thr_q   <= thr_d;
      omb_q   <= omb_d;
      ombf_q  <= ombf_d;
      imb_q   <= imb_d;
      imbf_q  <= imbf_d;
      rstf_q  <= rstf_d;
      gate_q  <= gate_d;
      tcnt_q  <= tcnt_d;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (dat_rd) begin
      host_rdata = in_dout[BYTE_W-1:0];
    end else if (st_rd) begin
      host_rdata = shift_q ? st_other : st_norm;
    end else if (reg_rd) begin
      case (sel)
        SEL_CMD:   host_rdata = {1'b0, shift_q, 6'b0};
        SEL_MASK:  host_rdata = {1'b0, mask_q, 1'b0};
        SEL_MATCH: host_rdata = match_q;
        SEL_OMBX:  host_rdata = omb_q;
        SEL_THR:   host_rdata = thr_q;
        SEL_IMBX:  host_rdata = imb_q;
        default:   host_rdata = '0;
      endcase
    end
  end

  assign host_irq       = gate_q & (rstf_q | (|(st_norm[6:1] & mask_q)));
  assign loc_rdata      = out_dout;
  assign loc_out_empty  = out_empty;
  assign loc_in_full    = in_full;
  assign loc_mbox_rdata = omb_q;
  assign loc_mbox_full  = ombf_q;

  // R2: reading status in pointer mode clears the sticky reset flag
  assert_stclr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd |=> !rstf_q);
  // R10: a command reset closes the interrupt gate
  assert_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rst |=> !host_irq);
  // R8: consumption by the local side reads back as zero
  assert_mbox_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_mbox_rd && !(reg_wr && sel == SEL_OMBX)) |=> (loc_mbox_rdata == '0 && !loc_mbox_full));
  // R7: no tagged byte can remain in an empty inbound queue
  assert_match_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_empty |-> (tcnt_q == '0));
  // R9: a local mailbox write always leaves the mailbox full
  assert_imbx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_mbox_wr && !cmd_rst) |=> imbf_q);
endmodule

// File: tb/test_fifo_regport.sv
module test_fifo_regport;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 0, host_rd = 0, host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic       host_irq;
  logic       loc_wr = 0, loc_rd = 0, loc_mbox_wr = 0, loc_mbox_rd = 0, loc_irq_en = 0;
  logic [7:0] loc_wdata = 0, loc_mbox_wdata = 0;
  logic [7:0] loc_rdata, loc_mbox_rdata;
  logic       loc_out_empty, loc_in_full, loc_mbox_full;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fifo_regport i_fifo_regport (
    .clk (clk), .rst_n (rst_n),
    .host_wr (host_wr), .host_rd (host_rd), .host_addr (host_addr),
    .host_wdata (host_wdata), .host_rdata (host_rdata), .host_irq (host_irq),
    .loc_wr (loc_wr), .loc_wdata (loc_wdata), .loc_rd (loc_rd), .loc_rdata (loc_rdata),
    .loc_out_empty (loc_out_empty), .loc_in_full (loc_in_full),
    .loc_mbox_wr (loc_mbox_wr), .loc_mbox_wdata (loc_mbox_wdata),
    .loc_mbox_rd (loc_mbox_rd), .loc_mbox_rdata (loc_mbox_rdata),
    .loc_mbox_full (loc_mbox_full), .loc_irq_en (loc_irq_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input logic a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 0;
  endtask

  task automatic hr(input logic a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1; host_addr = a;
    #1 d = host_rdata;
    @(posedge clk); #1;
    host_rd = 0;
  endtask

  task automatic wreg(input logic [2:0] s, input logic [7:0] d);
    hw(1, {5'b0, s});
    hw(1, d);
  endtask

  task automatic rreg(input logic [2:0] s, output logic [7:0] d);
    hw(1, {5'b0, s});
    hr(1, d);
  endtask

  task automatic lpush(input logic [7:0] d);
    @(negedge clk);
    loc_wr = 1; loc_wdata = d;
    @(posedge clk); #1;
    loc_wr = 0;
  endtask

  task automatic lpop(output logic [7:0] d);
    @(negedge clk);
    loc_rd = 1;
    #1 d = loc_rdata;
    @(posedge clk); #1;
    loc_rd = 0;
  endtask

  task automatic pulse_irq_en();
    @(negedge clk); loc_irq_en = 1;
    @(posedge clk); #1; loc_irq_en = 0;
  endtask

  task automatic pulse_mbox_rd();
    @(negedge clk); loc_mbox_rd = 1;
    @(posedge clk); #1; loc_mbox_rd = 0;
  endtask

  task automatic lmbox(input logic [7:0] d);
    @(negedge clk); loc_mbox_wr = 1; loc_mbox_wdata = d;
    @(posedge clk); #1; loc_mbox_wr = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    tests++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state, R3 and R2
    chk("R3 irq off after reset", host_irq, 0);
    chk("R3 out queue empty", loc_out_empty, 1);
    chk("R3 out mailbox empty", loc_mbox_full, 0);
    hr(1, v); chk("R2 status after reset", v, 8'hA8);
    hr(1, v); chk("R2 reset flag cleared by read", v, 8'h28);

    // R1 pointer behaviour
    wreg(3, 8'h5A);
    rreg(3, v); chk("R1 match readback", v, 8'h5A);
    hr(1, v); chk("R1 back to status", v, 8'h28);
    hw(1, 8'd5); hw(0, 8'h99); hw(1, 8'h10);
    rreg(5, v); chk("R1 selection survives data access", v, 8'h10);
    hw(1, 8'd7); hr(1, v); chk("R1 select 7 reads zero", v, 8'h00);
    hr(1, v); chk("R1 status after null select", v, 8'h28);
    hw(1, 8'd0); hw(1, 8'hFF);
    rreg(3, v); chk("R1 select 0 write reaches nothing", v, 8'h5A);

    // R3 command reset
    chk("R3 out queue holds byte", loc_out_empty, 0);
    wreg(1, 8'h80);
    chk("R3 cmd reset empties out queue", loc_out_empty, 1);
    hr(1, v); chk("R3 status after cmd reset", v, 8'hA8);
    rreg(5, v); chk("R3 threshold kept", v, 8'h10);

    // R5/R6 outbound sweep, threshold 16
    for (int k = 1; k <= 512; k++) begin
      hw(0, 8'((k * 7 + 3) & 8'hFF));
      hr(1, v);
      chk("R6 outbound almost full", v[4], (k >= 512 - 16));
    end
    chk("R5 outbound full bit", v[6], 1);
    hw(0, 8'hEE);
    for (int k = 1; k <= 512; k++) begin
      lpop(v);
      chk("R5 outbound order", v, 8'((k * 7 + 3) & 8'hFF));
    end
    chk("R5 full push dropped", loc_out_empty, 1);

    // R5/R6 inbound sweep
    for (int k = 0; k < 512; k++) lpush(8'((k * 13 + 5) & 8'hFF));
    chk("R5 inbound full", loc_in_full, 1);
    lpush(8'hEE);
    for (int k = 0; k < 512; k++) begin
      hr(0, v);
      chk("R5 inbound order", v, 8'((k * 13 + 5) & 8'hFF));
      hr(1, v);
      chk("R6 inbound almost empty", v[3], ((511 - k) <= 16));
    end
    hr(0, v); chk("R5 empty pop reads zero", v, 8'h00);
    hr(1, v); chk("R5 empty after drain", v[5], 1);

    // R7 byte-match with simultaneous push and pop
    wreg(1, 8'h80);
    lpush(8'h11); lpush(8'h5A); lpush(8'h22);
    hr(1, v); chk("R7 match present", v[1], 1);
    hr(0, v); chk("R7 first byte", v, 8'h11);
    hr(1, v); chk("R7 still present", v[1], 1);
    @(negedge clk);
    host_rd = 1; host_addr = 0; loc_wr = 1; loc_wdata = 8'h5A;
    #1 v = host_rdata;
    @(posedge clk); #1;
    host_rd = 0; loc_wr = 0;
    chk("R7 concurrent pop data", v, 8'h5A);
    hr(1, v); chk("R7 flag kept over concurrent push/pop", v[1], 1);
    hr(0, v); chk("R7 untagged byte", v, 8'h22);
    hr(1, v); chk("R7 flag with tagged byte queued", v[1], 1);
    hr(0, v); chk("R7 last tagged byte", v, 8'h5A);
    hr(1, v); chk("R7 flag clear after drain", v[1], 0);

    // R8 outbound mailbox
    wreg(1, 8'h80);
    wreg(4, 8'h3C);
    chk("R8 mailbox full", loc_mbox_full, 1);
    chk("R8 mailbox data", loc_mbox_rdata, 8'h3C);
    rreg(4, v); chk("R8 readback", v, 8'h3C);
    pulse_mbox_rd();
    rreg(4, v); chk("R8 consumed reads zero", v, 8'h00);
    chk("R8 full cleared", loc_mbox_full, 0);

    // R4 shifted status view
    wreg(1, 8'h80);
    hr(1, v);
    wreg(1, 8'h40);
    rreg(1, v); chk("R4 command readback", v, 8'h40);
    hr(1, v); chk("R4 other view idle", v, 8'h20);
    hw(0, 8'h12);
    hr(1, v); chk("R4 other view out non-empty", v, 8'h00);
    wreg(4, 8'h33);
    hr(1, v); chk("R4 other view mailbox", v, 8'h04);
    wreg(1, 8'h00);
    hr(1, v); chk("R4 normal view restored", v, 8'h28);

    // R9 / R10 mailbox and interrupts
    wreg(1, 8'h80);
    hr(1, v);
    wreg(2, 8'hFF);
    rreg(2, v); chk("R10 mask drops bits 7 and 0", v, 8'h7E);
    wreg(2, 8'h04);
    lmbox(8'h77);
    chk("R10 gate closed", host_irq, 0);
    hr(1, v); chk("R9 inbound mailbox full bit", v, 8'h2C);
    pulse_irq_en();
    chk("R10 masked source interrupts", host_irq, 1);
    rreg(6, v); chk("R9 inbound mailbox data", v, 8'h77);
    chk("R10 irq falls with source", host_irq, 0);
    hr(1, v); chk("R9 full bit cleared", v, 8'h28);
    wreg(1, 8'h80);
    chk("R10 cmd reset closes gate", host_irq, 0);
    pulse_irq_en();
    chk("R10 reset flag unmaskable", host_irq, 1);
    hr(1, v); chk("R2 status with flag", v, 8'hA8);
    chk("R10 irq clears with flag", host_irq, 0);

    summary();
  end
endmodule